// File: doc/BRIEF.md
# I2C Receive Acknowledge and Packet-Error-Check Controller

This block sits beside the bit engine of a multi-master I2C port. It holds the CPU-visible 8-bit control register and decides, after every received byte, whether ACK or NACK goes out in the ninth clock slot. In master and in slave receive it keeps a running CRC-8 over the bytes of the current transfer. When software marks the next byte as the packet-error-check byte, that byte is compared against the running CRC. In slave receive a mismatch forces NACK.

The block also keeps four event flags and a bus-busy flag. It merges the event flags into one interrupt request and hands the bit engine a repeated-start request. The bit engine reports START, STOP, received bytes, completed repeated starts and the current master state through single-cycle pulses and levels. The CPU writes the register through a simple synchronous port and reads it back at any time.

Top module: `i2c_rx_ackpec`

## Requirements
- R1: While the enable bit is 0, the four event flags, `bus_busy`, `crc_err` and `ack_valid` are all 0 from the next cycle on, and no acknowledge decision is produced.
- R2: `irq` is 1 only when the interrupt-enable bit is 1 and at least one event flag is set. The flags are `flags[0]` transmit, `flags[1]` receive, `flags[2]` arbitration lost and `flags[3]` NACK. Each flag is set by `flag_set` and cleared by `flag_clr`.
- R3: `bus_busy` sets on `start_seen`. It clears on `stop_seen` or on a register write with bit 5 at 1. Bit 5 always reads back as 0.
- R4: One cycle after `byte_valid` on a byte not marked as PEC, `ack_valid` is 1 and `ack_drive` equals the inverse of the acknowledge-disable bit (bit 2).
- R5: `rstart_req` is 1 when the module is enabled, the repeated-start bit (bit 1) is set and `master_mode` is 1. Hardware clears bit 1 on `rstart_done` or when `master_mode` falls. A hardware clear wins over a write in the same cycle.
- R6: `crc_out` is a CRC-8 with polynomial 0x07 and initial value 0. It is cleared on `start_seen` and updated with every received byte, MSB first.
- R7: In master receive with the PEC bit (bit 0) set, `ack_drive` depends on the acknowledge-disable bit alone, whatever the CRC comparison gives.
- R8: In slave receive with the PEC bit set, a received byte that differs from `crc_out` gives NACK. A matching byte gives ACK only when bit 2 is 0. In either mode a mismatch sets `crc_err`, which stays set until the next START.
- R9: The PEC bit clears itself in the cycle the PEC byte's decision is taken.
- R10: The register reads back as {enable, interrupt enable, 0, 0, 0, ack disable, repeated start, PEC} from bit 7 down to bit 0. It resets to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register address match |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| master_mode | input | 1 | Bit engine is master of the current transfer |
| start_seen | input | 1 | START or repeated START detected (pulse) |
| stop_seen | input | 1 | STOP detected (pulse) |
| rstart_done | input | 1 | Repeated START generation finished (pulse) |
| byte_valid | input | 1 | Eight bits received (pulse) |
| rx_byte | input | 8 | Received byte |
| flag_set | input | NFLAG | Event flag set pulses |
| flag_clr | input | NFLAG | Event flag clear pulses |
| flags | output | NFLAG | Event flags |
| irq | output | 1 | Interrupt request |
| bus_busy | output | 1 | Bus-busy flag |
| ack_valid | output | 1 | Acknowledge decision ready (pulse) |
| ack_drive | output | 1 | 1 = drive ACK, 0 = NACK |
| rstart_req | output | 1 | Repeated START request to the bit engine |
| crc_out | output | 8 | Running CRC of the transfer |
| crc_err | output | 1 | PEC mismatch latched |

## Verification
On every cycle the assertions check the interrupt gating, the clearing caused by disable, the busy clear on STOP, the self-clearing of the repeated-start and PEC bits, forced NACK when acknowledge is disabled, and the two PEC outcomes: ACK in master mode and NACK in slave mode on a mismatch. Only the bench's scenarios show that the CRC value itself is right, that a correct PEC byte is accepted in each mode and ackdisable setting, and that the register reads back with its reserved and write-only bits as 0.

// File: rtl/i2c_rx_ackpec.sv
module i2c_rx_ackpec #(
  parameter int          NFLAG = 4,
  parameter logic [7:0]  POLY  = 8'h07
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             master_mode,
  input  logic             start_seen,
  input  logic             stop_seen,
  input  logic             rstart_done,
  input  logic             byte_valid,
  input  logic [7:0]       rx_byte,
  input  logic [NFLAG-1:0] flag_set,
  input  logic [NFLAG-1:0] flag_clr,
  output logic [NFLAG-1:0] flags,
  output logic             irq,
  output logic             bus_busy,
  output logic             ack_valid,
  output logic             ack_drive,
  output logic             rstart_req,
  output logic [7:0]       crc_out,
  output logic             crc_err
);

  logic en, ie, ackdis, repsen, pec, master_q;
  logic wr, pec_match, ack_next;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    for (int i = 0; i < 8; i++)
      x = x[7] ? ((x << 1) ^ POLY) : (x << 1);
    return x;
  endfunction

  assign wr         = reg_we & reg_sel;
  assign pec_match  = (rx_byte == crc_out);
  assign ack_next   = !ackdis && (master_mode || !pec || pec_match);
  assign reg_rdata  = {en, ie, 3'b000, ackdis, repsen, pec};
  assign irq        = ie & (|flags);
  assign rstart_req = en & repsen & master_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= 1'b0;
      ie       <= 1'b0;
      ackdis   <= 1'b0;
      repsen   <= 1'b0;
      pec      <= 1'b0;
      master_q <= 1'b0;
    end else begin
      master_q <= master_mode;
      if (wr) begin
        en     <= reg_wdata[7];
        ie     <= reg_wdata[6];
        ackdis <= reg_wdata[2];
        repsen <= reg_wdata[1];
        pec    <= reg_wdata[0];
      end
      if (rstart_done || (master_q && !master_mode))
        repsen <= 1'b0;
      if (en && byte_valid && pec)
        pec <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      flags     <= '0;
      bus_busy  <= 1'b0;
      crc_out   <= 8'h00;
      crc_err   <= 1'b0;
      ack_valid <= 1'b0;
      ack_drive <= 1'b0;
    end else begin
      flags     <= (flags & ~flag_clr) | flag_set;
      ack_valid <= byte_valid;
      if (byte_valid)
        ack_drive <= ack_next;
      if (start_seen) begin
        bus_busy <= 1'b1;
        crc_out  <= 8'h00;
        crc_err  <= 1'b0;
      end else if (byte_valid) begin
        crc_out <= crc_step(crc_out, rx_byte);
        if (pec && !pec_match)
          crc_err <= 1'b1;
      end
      if (stop_seen || (wr && reg_wdata[5]))
        bus_busy <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_rx_ackpec_chk.sv
module i2c_rx_ackpec_chk #(
  parameter int NFLAG = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       reg_rdata,
  input logic             master_mode,
  input logic             start_seen,
  input logic             stop_seen,
  input logic             rstart_done,
  input logic             byte_valid,
  input logic [7:0]       rx_byte,
  input logic [NFLAG-1:0] flags,
  input logic             irq,
  input logic             bus_busy,
  input logic             ack_valid,
  input logic             ack_drive,
  input logic [7:0]       crc_out,
  input logic             crc_err
);

  logic en_c, ie_c, ackdis_c, pec_c;
  assign en_c     = reg_rdata[7];
  assign ie_c     = reg_rdata[6];
  assign ackdis_c = reg_rdata[2];
  assign pec_c    = reg_rdata[0];

  p_disable_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_c |=> (flags == '0 && !bus_busy && !crc_err && !ack_valid));

  p_irq_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_c |-> !irq);

  p_stop_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !bus_busy);

  p_ackdis_nack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_c && byte_valid && ackdis_c) |=> (ack_valid && !ack_drive));

  p_repsen_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rstart_done |=> !reg_rdata[1]);

  p_master_pec_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_c && byte_valid && pec_c && master_mode && !ackdis_c) |=> (ack_valid && ack_drive));

  p_slave_pec_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_c && byte_valid && pec_c && !master_mode && !start_seen && rx_byte != crc_out)
      |=> (ack_valid && !ack_drive && crc_err));

  p_pec_autoclear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_c && byte_valid && pec_c) |=> !reg_rdata[0]);

endmodule

bind i2c_rx_ackpec i2c_rx_ackpec_chk #(.NFLAG(NFLAG)) u_chk (.*);

// File: tb/i2c_rx_ackpec_bench.sv
module i2c_rx_ackpec_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 0, reg_sel = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic master_mode = 0, start_seen = 0, stop_seen = 0, rstart_done = 0, byte_valid = 0;
  logic [7:0] rx_byte = 0;
  logic [3:0] flag_set = 0, flag_clr = 0, flags;
  logic irq, bus_busy, ack_valid, ack_drive, rstart_req, crc_err;
  logic [7:0] crc_out;

  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  i2c_rx_ackpec u_i2c_rx_ackpec (.*);

  // {master, ackdis, good_pec, exp_ack, exp_err}
  localparam logic [4:0] VEC [8] = '{
    5'b10110, 5'b10011, 5'b11100, 5'b11001,
    5'b00110, 5'b00001, 5'b01100, 5'b01001 };

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = r[7] ^ d[i];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    reg_we = 1; reg_sel = 1; reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_sel = 0;
  endtask

  task automatic send(input logic [7:0] b);
    byte_valid = 1; rx_byte = b;
    @(negedge clk);
    byte_valid = 0;
  endtask

  task automatic pulse_start();
    start_seen = 1; @(negedge clk); start_seen = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset rdata", reg_rdata, 8'h00);
    chk("R2 reset irq", {7'b0, irq}, 8'h00);
    chk("R1 reset busy", {7'b0, bus_busy}, 8'h00);

    for (int i = 0; i < 8; i++) begin
      logic [4:0] v;
      v = VEC[i];
      master_mode = v[4];
      wr({5'b10000, v[3], 2'b00});
      pulse_start();
      send(8'hA5);
      chk("R4 ack_valid", {7'b0, ack_valid}, 8'h01);
      chk("R4 ack_drive", {7'b0, ack_drive}, {7'b0, ~v[3]});
      send(8'h3C);
      c = ref_crc(ref_crc(8'h00, 8'hA5), 8'h3C);
      chk("R6 crc", crc_out, c);
      wr({5'b10000, v[3], 2'b01});
      send(v[2] ? c : (c ^ 8'h01));
      chk(v[4] ? "R7 pec ack" : "R8 pec ack", {7'b0, ack_drive}, {7'b0, v[1]});
      chk("R8 crc_err", {7'b0, crc_err}, {7'b0, v[0]});
      chk("R9 pec cleared", {7'b0, reg_rdata[0]}, 8'h00);
    end
    master_mode = 0;
    @(negedge clk);

    wr(8'hFF);
    chk("R10 readback", reg_rdata, 8'hC7);
    wr(8'hC0);
    flag_set = 4'b0100; @(negedge clk); flag_set = 0;
    chk("R2 flags", {4'b0, flags}, 8'h04);
    chk("R2 irq on", {7'b0, irq}, 8'h01);
    wr(8'h80);
    chk("R2 irq masked", {7'b0, irq}, 8'h00);
    flag_clr = 4'b0100; @(negedge clk); flag_clr = 0;
    chk("R2 flag cleared", {4'b0, flags}, 8'h00);

    pulse_start();
    chk("R3 busy set", {7'b0, bus_busy}, 8'h01);
    wr(8'hA0);
    chk("R3 busy write-clear", {7'b0, bus_busy}, 8'h00);
    chk("R3 clear bit reads 0", reg_rdata, 8'h80);
    pulse_start();
    stop_seen = 1; @(negedge clk); stop_seen = 0;
    chk("R3 busy stop", {7'b0, bus_busy}, 8'h00);

    master_mode = 1;
    wr(8'h82);
    chk("R5 rstart_req", {7'b0, rstart_req}, 8'h01);
    rstart_done = 1; @(negedge clk); rstart_done = 0;
    chk("R5 done clears", {7'b0, reg_rdata[1]}, 8'h00);
    wr(8'h82);
    master_mode = 0;
    @(negedge clk);
    chk("R5 master fall clears", {7'b0, reg_rdata[1]}, 8'h00);

    wr(8'hC0);
    flag_set = 4'b1001; pulse_start(); flag_set = 0;
    wr(8'h00);
    @(negedge clk);
    chk("R1 flags cleared", {4'b0, flags}, 8'h00);
    chk("R1 busy cleared", {7'b0, bus_busy}, 8'h00);
    send(8'h55);
    chk("R1 no decision", {7'b0, ack_valid}, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule